// File: doc/BRIEF.md
# Parallel Nonvolatile Memory Page-Load Controller

This block is the write front end of a byte-wide parallel nonvolatile memory model, clocked by a system clock and driven by three asynchronous active-low pins: chip select, write strobe and output enable. It brings the pins into the clock domain and finds the start and the end of each write cycle. The start of a cycle is the later of the two strobe falling edges, and the block takes the address there. The end of a cycle is the earlier of the two strobe rising edges, and the block takes the data there. Each accepted byte goes into a page buffer slot chosen by the low address bits, and a per-slot valid mask records which slots hold a byte.

The first byte of a session fixes the page. Each later byte must name the same page. When no new accepted write begins within a load window, the block starts an internal programming period and raises a busy flag for a fixed number of cycles. The buffer contents can be read out through an offset port by whatever does the programming. When the busy period ends, the valid mask clears and a new session may open on any page.

Top module: `pgl_top`

## Requirements
- R1: After reset, `busy`, `progStart` and `pageErr` are low and `validMask` is all zeros.
- R2: A write cycle exists only while chip select and write strobe are both low and output enable is high. A strobe pair with output enable low, or a write strobe with chip select high, loads nothing.
- R3: The address is taken when the later of the two strobes falls. Address changes after that point do not move the byte.
- R4: The data is taken when the earlier of the two strobes rises. Data changes after that point do not alter the stored byte.
- R5: A page holds `2**OFF_W` bytes (128 by default). The byte lands in the slot given by address bits `OFF_W-1:0` and sets that bit of `validMask`. `rdData` returns the slot selected by `rdOffset`.
- R6: In an open session, a write whose page field (address bits `ADDR_W-1:OFF_W`) differs from the session page is ignored: no buffer, mask or timer change. `pageErr` pulses for exactly one clock.
- R7: `progStart` pulses for one clock when `WINDOW_CYC` cycles pass from the last accepted cycle start with no new accepted start. Sampled between edges, it shows exactly `WINDOW_CYC+2` cycles after the clock cycle in which the later strobe pin fell.
- R8: `busy` rises in the cycle after `progStart` and stays high for exactly `PROG_CYC` cycles. When it falls, `validMask` is all zeros.
- R9: Write cycles that start while `busy` is high are ignored.
- R10: `pageNum` reports the page field of the first accepted byte of the session. A new session after programming may use any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip select pin, active low, asynchronous |
| weN | input | 1 | Write strobe pin, active low, asynchronous |
| oeN | input | 1 | Output enable pin, active low, asynchronous |
| addrIn | input | ADDR_W | Address pins |
| dataIn | input | DATA_W | Data pins (write direction) |
| rdOffset | input | OFF_W | Buffer slot to read out |
| rdData | output | DATA_W | Buffered byte at `rdOffset` |
| validMask | output | 2**OFF_W | One bit per buffered slot |
| pageNum | output | ADDR_W-OFF_W | Page of the open session |
| busy | output | 1 | Internal programming in progress |
| progStart | output | 1 | One-clock pulse when programming begins |
| pageErr | output | 1 | One-clock pulse on a write to a different page |

## Verification
The assertions assume that the address and data pins stay steady for at least three clocks around the synchronised strobe edge where each is taken. They also assume that every strobe level lasts at least two clocks, so that no pulse disappears inside the synchronisers. The stimulus changes pins only on falling clock edges, spaces strobe transitions by two or more clocks, and alters address and data only five clocks after the relevant edge. This is late enough to confirm that the captures ignored the change, yet the change stays within the window. The bench sweeps every slot of a page, alternating which strobe leads, and it times the load window and the busy period to the exact cycle.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pglState_t;

  typedef struct packed {
    logic latchAddr;
    logic setPage;
    logic commitByte;
    logic clearAll;
  } dpCtrl_t;

endpackage

// File: rtl/pgl_pin_sync.sv
module pgl_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '1;
        end else if (s == 0) begin
          stageQ[s] <= pinIn;
        end else begin
          stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign pinSync = stageQ[STAGES-1];

endmodule

// File: rtl/pgl_datapath.sv
module pgl_datapath
  import pgl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrl_t                 ctrl,
  input  logic [ADDR_W-1:0]       addrPin,
  input  logic [DATA_W-1:0]       dataPin,
  input  logic [OFF_W-1:0]        rdOffset,
  output logic                    pageMatch,
  output logic [ADDR_W-OFF_W-1:0] pageNum,
  output logic [(1<<OFF_W)-1:0]   validMask,
  output logic [DATA_W-1:0]       rdData
);

  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [OFF_W-1:0]  slotReg;
  logic [PAGE_W-1:0] pageReg;
  logic [DATA_W-1:0] bufMem [PAGE_BYTES];

  assign pageMatch = (addrPin[ADDR_W-1:OFF_W] == pageReg);
  assign pageNum   = pageReg;
  assign rdData    = bufMem[rdOffset];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotReg <= '0;
      pageReg <= '0;
    end else begin
      if (ctrl.latchAddr) slotReg <= addrPin[OFF_W-1:0];
      if (ctrl.setPage)   pageReg <= addrPin[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMask <= '0;
    end else if (ctrl.clearAll) begin
      validMask <= '0;
    end else if (ctrl.commitByte) begin
      validMask[slotReg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.commitByte) bufMem[slotReg] <= dataPin;
  end

  // Mask only moves on a commit or a clear (R9, R6)
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.commitByte && !ctrl.clearAll) |=> $stable(validMask));

  // A committed byte marks its slot (R5)
  assert_commit_marks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.commitByte && !ctrl.clearAll) |=> validMask[$past(slotReg)]);

endmodule

// File: rtl/pgl_control.sv
module pgl_control
  import pgl_pkg::*;
#(
  parameter int WINDOW_CYC = 5000,
  parameter int PROG_CYC   = 150000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceS,
  input  logic    weS,
  input  logic    oeS,
  input  logic    pageMatch,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    progStart,
  output logic    pageErr
);

  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  pglState_t   state;
  logic        prevActive;
  logic        inCycle;
  logic [WIN_W-1:0]  winCnt;
  logic [PROG_W-1:0] progCnt;

  logic activeS, startEdge, endEdge, accept, expire, progDone;

  assign activeS   = !ceS && !weS && oeS;
  assign startEdge = activeS && !prevActive;
  assign endEdge   = !activeS && prevActive;
  assign accept    = startEdge && (state == ST_IDLE || (state == ST_LOAD && pageMatch));
  assign pageErr   = startEdge && (state == ST_LOAD) && !pageMatch;
  assign expire    = (state == ST_LOAD) && (winCnt == WIN_W'(WINDOW_CYC - 1)) && !activeS;
  assign progDone  = (state == ST_PROG) && (progCnt == PROG_W'(PROG_CYC - 1));
  assign progStart = expire;
  assign busy      = (state == ST_PROG);

  always_comb begin
    ctrl            = '0;
    ctrl.latchAddr  = accept;
    ctrl.setPage    = accept && (state == ST_IDLE);
    ctrl.commitByte = endEdge && inCycle && (ceS || weS);
    ctrl.clearAll   = progDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      inCycle    <= 1'b0;
    end else begin
      prevActive <= activeS;
      if (accept)       inCycle <= 1'b1;
      else if (endEdge) inCycle <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (accept) begin
      winCnt <= '0;
    end else if (state != ST_PROG && winCnt != WIN_W'(WINDOW_CYC - 1)) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      progCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ctrl.commitByte) state <= ST_LOAD;
        ST_LOAD: if (expire) begin
          state   <= ST_PROG;
          progCnt <= '0;
        end
        ST_PROG: begin
          if (progDone) state <= ST_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Programming starts right after the window closes (R7)
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> busy);

  // Busy period starts with a fresh counter (R8)
  assert_busy_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (progCnt == '0));

  // Page error is a single-clock pulse outside busy (R6)
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> !pageErr);
  assert_err_not_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |-> !busy);

  // No byte lands while programming (R9)
  assert_no_commit_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrl.commitByte);

endmodule

// File: rtl/pgl_top.sv
module pgl_top
  import pgl_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = 7,
  parameter int SYNC_STG   = 2,
  parameter int WINDOW_CYC = 5000,
  parameter int PROG_CYC   = 150000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic [OFF_W-1:0]        rdOffset,
  output logic [DATA_W-1:0]       rdData,
  output logic [(1<<OFF_W)-1:0]   validMask,
  output logic [ADDR_W-OFF_W-1:0] pageNum,
  output logic                    busy,
  output logic                    progStart,
  output logic                    pageErr
);

  logic [2:0] pinSync;
  logic       pageMatch;
  dpCtrl_t    ctrl;

  pgl_pin_sync #(.WIDTH(3), .STAGES(SYNC_STG)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   ({ceN, weN, oeN}),
    .pinSync (pinSync)
  );

  pgl_control #(.WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ceS       (pinSync[2]),
    .weS       (pinSync[1]),
    .oeS       (pinSync[0]),
    .pageMatch (pageMatch),
    .ctrl      (ctrl),
    .busy      (busy),
    .progStart (progStart),
    .pageErr   (pageErr)
  );

  pgl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .addrPin   (addrIn),
    .dataPin   (dataIn),
    .rdOffset  (rdOffset),
    .pageMatch (pageMatch),
    .pageNum   (pageNum),
    .validMask (validMask),
    .rdData    (rdData)
  );

  // Start and error never coincide (R6, R7)
  assert_single_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, pageErr}));

  // Leaving the busy period leaves an empty page (R8)
  assert_clear_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (validMask == '0));

endmodule

// File: tb/pgl_top_tb_top.sv
`timescale 1ns/1ps
module pgl_top_tb_top;

  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 7;
  localparam int NBYTES = 1 << OFF_W;
  localparam int WIN    = 40;
  localparam int PROG   = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [OFF_W-1:0]  rdOffset = '0;
  logic [DATA_W-1:0] rdData;
  logic [NBYTES-1:0] validMask;
  logic [ADDR_W-OFF_W-1:0] pageNum;
  logic busy, progStart, pageErr;

  int checks = 0, errors = 0;
  int cyc = 0;
  int errPulses = 0, startPulses = 0, busyCycles = 0;
  int lastStartPinCyc = 0, lastProgCyc = 0;

  always #10 clk = ~clk;

  pgl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W),
            .WINDOW_CYC(WIN), .PROG_CYC(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addrIn(addrIn), .dataIn(dataIn), .rdOffset(rdOffset), .rdData(rdData),
    .validMask(validMask), .pageNum(pageNum), .busy(busy),
    .progStart(progStart), .pageErr(pageErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pageErr) errPulses++;
    if (progStart) begin
      startPulses++;
      lastProgCyc = cyc;
    end
    if (busy) busyCycles++;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One write cycle; the later falling strobe is chosen by ceFirst.
  // Address and data are disturbed after their capture points (R3, R4).
  task automatic doWrite(input int addr, input int data, input bit ceFirst);
    @(negedge clk);
    addrIn = ADDR_W'(addr);
    dataIn = DATA_W'(data);
    if (ceFirst) ceN = 1'b0; else weN = 1'b0;
    waitNeg(2);
    if (ceFirst) weN = 1'b0; else ceN = 1'b0;
    lastStartPinCyc = cyc;
    waitNeg(5);
    addrIn = addrIn ^ ADDR_W'(1);
    if (ceFirst) weN = 1'b1; else ceN = 1'b1;
    waitNeg(5);
    dataIn = ~dataIn;
    if (ceFirst) ceN = 1'b1; else weN = 1'b1;
    waitNeg(3);
  endtask

  function automatic logic [7:0] patt(input int off, input int page);
    return 8'((off * 37 + page * 11 + 5) & 8'hFF);
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int errBefore, startBefore;
    bit allOk;
    waitNeg(3);
    // R1 reset state
    check(!busy && !progStart && !pageErr, "R1 flags", {busy, progStart, pageErr}, 0);
    check(validMask == '0, "R1 mask", validMask, 0);
    rstN = 1'b1;
    waitNeg(3);

    // R2 blocked writes: output enable low, then chip select high
    oeN = 1'b0; ceN = 1'b0; weN = 1'b0; addrIn = 15'h0283; dataIn = 8'h5A;
    waitNeg(8);
    weN = 1'b1; waitNeg(4); ceN = 1'b1; oeN = 1'b1;
    waitNeg(4);
    weN = 1'b0; waitNeg(8); weN = 1'b1;
    waitNeg(WIN + 10);
    check(validMask == '0, "R2 mask after blocked strobes", validMask, 0);
    check(!busy && startPulses == 0, "R2 no programming", startPulses, 0);

    // R5 full-page sweep, alternating leading strobe (R3, R4 on every byte)
    for (int o = 0; o < NBYTES; o++) doWrite((5 << OFF_W) | o, patt(o, 5), o[0]);
    check(validMask == {NBYTES{1'b1}}, "R5 full mask", validMask, {NBYTES{1'b1}});
    check(pageNum == 8'd5, "R10 session page", pageNum, 5);
    allOk = 1'b1;
    for (int o = 0; o < NBYTES; o++) begin
      rdOffset = OFF_W'(o);
      #0.1;
      if (rdData != patt(o, 5)) begin
        allOk = 1'b0;
        $display("FAIL R5 slot %0d actual=%0h expected=%0h", o, rdData, patt(o, 5));
      end
    end
    check(allOk, "R3 R4 R5 buffered bytes", allOk, 1);

    // R6 write to another page: ignored, one pulse, timer untouched
    errBefore = errPulses;
    startBefore = lastStartPinCyc;
    doWrite((6 << OFF_W) | 3, 8'hEE, 1'b1);
    check(errPulses == errBefore + 1, "R6 one error pulse", errPulses - errBefore, 1);
    rdOffset = 7'd3; #0.1;
    check(rdData == patt(3, 5), "R6 slot unchanged", rdData, patt(3, 5));
    check(pageNum == 8'd5, "R6 page kept", pageNum, 5);

    // R7 expiry timed from last accepted start; R8 busy length and clear
    busyCycles = 0;
    while (startPulses == 0) @(negedge clk);
    check(lastProgCyc - startBefore == WIN + 2, "R7 window after sweep",
          lastProgCyc - startBefore, WIN + 2);
    @(negedge clk);
    check(busy, "R8 busy after start", busy, 1);
    while (busy) @(negedge clk);
    check(busyCycles == PROG, "R8 busy length", busyCycles, PROG);
    check(validMask == '0, "R8 mask cleared", validMask, 0);

    // R10 new session on another page, CE-controlled capture (R3, R4)
    doWrite((9 << OFF_W) | 20, 8'hC3, 1'b0);
    check(pageNum == 8'd9, "R10 new page", pageNum, 9);
    rdOffset = 7'd20; #0.1;
    check(rdData == 8'hC3, "R4 data at first rising edge", rdData, 8'hC3);
    check(validMask == (128'd1 << 20), "R3 address at later falling edge", validMask,
          128'd1 << 20);
    startBefore = startPulses;
    busyCycles = 0;
    while (startPulses == startBefore) @(negedge clk);
    check(lastProgCyc - lastStartPinCyc == WIN + 2, "R7 exact window",
          lastProgCyc - lastStartPinCyc, WIN + 2);
    check(startPulses == startBefore + 1, "R7 single pulse", startPulses - startBefore, 1);

    // R9 write during busy is ignored
    doWrite((9 << OFF_W) | 33, 8'h11, 1'b1);
    check(busy, "R9 still busy", busy, 1);
    while (busy) @(negedge clk);
    check(busyCycles == PROG, "R8 busy length second", busyCycles, PROG);
    waitNeg(WIN + 10);
    check(validMask == '0, "R9 busy write ignored", validMask, 0);
    check(startPulses == startBefore + 1 && !busy, "R9 no extra programming",
          startPulses, startBefore + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule